// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This engine moves received frames from a word-wide stream into host memory. It follows a ring of four-word descriptors that the host has prepared. The host hands a descriptor to the engine by setting bit 31 of its first word. The engine reads the buffer size and the buffer address from that descriptor and stores the incoming words there in order. When the frame ends, the engine writes a closing status word back and returns ownership to the host. A frame that is longer than one buffer continues into the next free descriptor. Before it closes a full buffer, the engine reads ahead to check that the next descriptor is free.

The engine runs while its run input is high. If it finds a host-owned descriptor, it suspends. It resumes on a poll-demand strobe, or on its own periodic re-poll. If the chain runs dry in the middle of a frame, two outcomes are possible:
- With flushing allowed, the open descriptor is closed with an error mark and the rest of the frame is discarded.
- With flushing disabled, the stream is stalled until a descriptor becomes available.

Memory reads return data one cycle after the request, and writes complete in the cycle they are issued.

Top module: `rxd_ring_dma`

## Requirements
- R1: After reset the engine is stopped: s_ready, mem_rd, mem_wr and every status output are low.
- R2: Raising run_en makes the engine read word 0 of the descriptor at the current ring position. If bit 31 of that word is 0 (host-owned), the engine suspends: stat_unavail pulses for one cycle and stat_susp goes high.
- R3: In an engine-owned descriptor, word 1 bits [15:0] give the buffer size in words (at least 1) and word 2 gives the buffer address. Stream words are stored at that address and the addresses after it, in arrival order.
- R4: When a frame's last word is stored, word 0 of the descriptor is rewritten as follows, and stat_done pulses once:
  - bit 31 (own) = 0
  - bit 30 (error) = 0
  - bit 29 = first buffer of the frame
  - bit 28 = last buffer of the frame
  - bits [15:0] = frame length in words up to and including this buffer
- R5: A buffer that fills before the frame ends is closed with first=1 or 0 as appropriate, last=0, and its cumulative length, provided the next descriptor is engine-owned. The frame then continues into that next descriptor's buffer, whose close has first=0.
- R6: Descriptors sit at ring_base + 4*index. After the last of RING_LEN descriptors, the index wraps to 0.
- R7: Suppose flush_dis is 0 and the next descriptor is host-owned while a frame is still incomplete. The open descriptor is then closed with bits 30, 29/28 as applicable and 28 set, and stat_desc_err pulses. The remaining words of the frame are accepted but never written to memory, after which the engine suspends at the next descriptor.
- R8: Under the same shortage with flush_dis at 1, s_ready stays low and the open descriptor stays engine-owned. Once the next descriptor is handed over and a poll is made, the open descriptor is closed normally and the frame continues without losing a word.
- R9: A poll_req pulse takes a suspended engine back to fetching at the same ring position it suspended on.
- R10: After POLL_CYCLES cycles in suspend without a poll_req, the engine re-reads the descriptor by itself and resumes if the descriptor is now engine-owned.
- R11: Lowering run_en while suspended or between frames returns the engine to stopped, with no further memory accesses and stat_run low.
- R12: A read and a write are never issued in the same cycle, and stream writes never go beyond the buffer size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Receive run enable |
| flush_dis | input | 1 | 1 = stall instead of discarding when descriptors run out mid-frame |
| poll_req | input | 1 | One-cycle poll-demand strobe |
| s_valid | input | 1 | Stream word valid |
| s_data | input | DW | Stream word |
| s_last | input | 1 | Marks the final word of a frame |
| s_ready | output | 1 | Engine accepts the stream word this cycle |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after mem_rd |
| stat_run | output | 1 | Engine is not stopped |
| stat_susp | output | 1 | Engine is suspended or stalled for descriptors |
| stat_done | output | 1 | Pulse: a frame was closed without error |
| stat_unavail | output | 1 | Pulse: a host-owned descriptor caused a suspend or stall |
| stat_desc_err | output | 1 | Pulse: a descriptor was closed with the error mark |

## Verification
The assertions rely on several properties of the surroundings:
- The host never takes back a descriptor it has handed to the engine.
- Every buffer size is at least one word.
- The memory always accepts a request in the cycle it is issued.

The bench keeps within these limits. It rewrites a descriptor only while the engine is suspended on it or has already closed it. It uses only non-zero sizes. Its memory model answers every read after exactly one cycle. Stream words are held stable until s_ready is seen, so no frame word is reordered or dropped by the stimulus itself.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [3:0] {
    S_STOP,
    S_FETCH,
    S_RD0,
    S_RD1,
    S_RD2,
    S_FILL,
    S_NXT,
    S_NXT_RD,
    S_CLOSE,
    S_DROP,
    S_SUSP,
    S_HOLD
  } rxd_state_e;

  localparam int OWN_BIT   = 31;
  localparam int ERR_BIT   = 30;
  localparam int FIRST_BIT = 29;
  localparam int LAST_BIT  = 28;
  localparam int DESC_WORDS = 4;

endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [IW-1:0] idx,
  output logic [IW-1:0] idx_nxt
);

  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

  always_comb begin
    if (idx == LAST_IDX) idx_nxt = '0;
    else                 idx_nxt = idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)      idx <= '0;
    else if (adv) idx <= idx_nxt;
  end

endmodule

// File: rtl/rxd_poll_timer.sv
module rxd_poll_timer #(
  parameter int CYC = 64,
  localparam int TW = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic fire
);

  logic [TW-1:0] cnt;

  assign fire = en && (cnt == TW'(CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !en || fire) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/rxd_close_word.sv
module rxd_close_word #(
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic [LW-1:0] len,
  input  logic          first,
  input  logic          last,
  input  logic          err,
  output logic [DW-1:0] word
);

  import rxd_pkg::*;

  always_comb begin
    word            = '0;
    word[LW-1:0]    = len;
    word[FIRST_BIT] = first;
    word[LAST_BIT]  = last;
    word[ERR_BIT]   = err;
    word[OWN_BIT]   = 1'b0;
  end

endmodule

// File: rtl/rxd_ring_dma.sv
module rxd_ring_dma #(
  parameter int AW          = 16,
  parameter int DW          = 32,
  parameter int LW          = 16,
  parameter int RING_BASE   = 0,
  parameter int RING_LEN    = 4,
  parameter int POLL_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          flush_dis,
  input  logic          poll_req,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          stat_run,
  output logic          stat_susp,
  output logic          stat_done,
  output logic          stat_unavail,
  output logic          stat_desc_err
);

  import rxd_pkg::*;

  localparam int IW = (RING_LEN > 1) ? $clog2(RING_LEN) : 1;
  localparam logic [AW-1:0] BASE = AW'(RING_BASE);

  rxd_state_e    state;
  logic [AW-1:0] buf_addr;
  logic [LW-1:0] buf_size;
  logic [LW-1:0] buf_cnt;
  logic [LW-1:0] frame_len;
  logic          in_frame;
  logic          cur_first;
  logic          cl_last;
  logic          cl_err;

  logic [IW-1:0] idx;
  logic [IW-1:0] idx_nxt;
  logic          ring_adv;
  logic          poll_fire;
  logic          poll_en;
  logic          accept;
  logic          resume;
  logic          rd_own;
  logic [DW-1:0] close_word;
  logic          unused_rdata;

  assign unused_rdata = ^mem_rdata;

  function automatic logic [AW-1:0] dadr(input logic [IW-1:0] i, input int w);
    return BASE + AW'({i, 2'b00}) + AW'(w);
  endfunction

  rxd_ring_ptr #(.N(RING_LEN), .IW(IW)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .adv     (ring_adv),
    .idx     (idx),
    .idx_nxt (idx_nxt)
  );

  rxd_poll_timer #(.CYC(POLL_CYCLES)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .en   (poll_en),
    .fire (poll_fire)
  );

  rxd_close_word #(.DW(DW), .LW(LW)) u_cw (
    .len   (frame_len),
    .first (cur_first),
    .last  (cl_last),
    .err   (cl_err),
    .word  (close_word)
  );

  assign poll_en  = (state == S_SUSP) || (state == S_HOLD);
  assign resume   = poll_req || poll_fire;
  assign s_ready  = (state == S_FILL) || (state == S_DROP);
  assign accept   = s_valid && s_ready;
  assign ring_adv = (state == S_CLOSE);
  assign rd_own   = mem_rdata[OWN_BIT];

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_FETCH: begin
        mem_rd   = run_en || in_frame;
        mem_addr = dadr(idx, 0);
      end
      S_RD0: begin
        mem_rd   = 1'b1;
        mem_addr = dadr(idx, 1);
      end
      S_RD1: begin
        mem_rd   = 1'b1;
        mem_addr = dadr(idx, 2);
      end
      S_NXT: begin
        mem_rd   = 1'b1;
        mem_addr = dadr(idx_nxt, 0);
      end
      S_FILL: begin
        mem_wr    = s_valid;
        mem_addr  = buf_addr + AW'(buf_cnt);
        mem_wdata = s_data;
      end
      S_CLOSE: begin
        mem_wr    = 1'b1;
        mem_addr  = dadr(idx, 0);
        mem_wdata = close_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_STOP;
      buf_addr      <= '0;
      buf_size      <= '0;
      buf_cnt       <= '0;
      frame_len     <= '0;
      in_frame      <= 1'b0;
      cur_first     <= 1'b0;
      cl_last       <= 1'b0;
      cl_err        <= 1'b0;
      stat_run      <= 1'b0;
      stat_susp     <= 1'b0;
      stat_done     <= 1'b0;
      stat_unavail  <= 1'b0;
      stat_desc_err <= 1'b0;
    end else begin
      stat_done     <= 1'b0;
      stat_unavail  <= 1'b0;
      stat_desc_err <= 1'b0;
      stat_run      <= (state != S_STOP);
      stat_susp     <= poll_en;
      case (state)
        S_STOP: begin
          if (run_en) state <= S_FETCH;
        end
        S_FETCH: begin
          if (!run_en && !in_frame) state <= S_STOP;
          else                      state <= S_RD0;
        end
        S_RD0: begin
          if (rd_own) begin
            state <= S_RD1;
          end else begin
            state        <= S_SUSP;
            stat_unavail <= 1'b1;
          end
        end
        S_RD1: begin
          buf_size <= mem_rdata[LW-1:0];
          state    <= S_RD2;
        end
        S_RD2: begin
          buf_addr  <= mem_rdata[AW-1:0];
          buf_cnt   <= '0;
          cur_first <= !in_frame;
          state     <= S_FILL;
        end
        S_FILL: begin
          if (accept) begin
            buf_cnt   <= buf_cnt + 1'b1;
            frame_len <= frame_len + 1'b1;
            in_frame  <= 1'b1;
            if (s_last) begin
              cl_last <= 1'b1;
              cl_err  <= 1'b0;
              state   <= S_CLOSE;
            end else if (buf_cnt + 1'b1 == buf_size) begin
              state <= S_NXT;
            end
          end
        end
        S_NXT: begin
          state <= S_NXT_RD;
        end
        S_NXT_RD: begin
          if (rd_own) begin
            cl_last <= 1'b0;
            cl_err  <= 1'b0;
            state   <= S_CLOSE;
          end else if (flush_dis) begin
            state        <= S_HOLD;
            stat_unavail <= 1'b1;
          end else begin
            cl_last <= 1'b1;
            cl_err  <= 1'b1;
            state   <= S_CLOSE;
          end
        end
        S_CLOSE: begin
          if (cl_err) begin
            stat_desc_err <= 1'b1;
            state         <= S_DROP;
          end else begin
            if (cl_last) begin
              stat_done <= 1'b1;
              frame_len <= '0;
              in_frame  <= 1'b0;
            end
            state <= S_FETCH;
          end
        end
        S_DROP: begin
          if (accept && s_last) begin
            frame_len    <= '0;
            in_frame     <= 1'b0;
            stat_unavail <= 1'b1;
            state        <= S_SUSP;
          end
        end
        S_SUSP: begin
          if (!run_en)     state <= S_STOP;
          else if (resume) state <= S_FETCH;
        end
        S_HOLD: begin
          if (resume) state <= S_NXT;
        end
        default: state <= S_STOP;
      endcase
    end
  end

endmodule

// File: rtl/rxd_ring_dma_chk.sv
module rxd_ring_dma_chk #(
  parameter int LW = 16
) (
  input logic                clk,
  input logic                rst,
  input rxd_pkg::rxd_state_e state,
  input logic                mem_rd,
  input logic                mem_wr,
  input logic                wdata_own,
  input logic                s_ready,
  input logic [LW-1:0]       buf_cnt,
  input logic [LW-1:0]       buf_size,
  input logic                stat_done,
  input logic                stat_desc_err
);

  import rxd_pkg::*;

  assert_no_access_stopped_R11: assert property (@(posedge clk) disable iff (rst)
    (state == S_STOP) |-> (!mem_rd && !mem_wr));

  assert_rd_wr_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_fill_in_bounds_R12: assert property (@(posedge clk) disable iff (rst)
    (state == S_FILL && mem_wr) |-> (buf_cnt < buf_size));

  assert_close_releases_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_CLOSE && mem_wr) |-> !wdata_own);

  assert_hold_stalls_R8: assert property (@(posedge clk) disable iff (rst)
    (state == S_HOLD) |-> !s_ready);

  assert_drop_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_DROP) |-> !mem_wr);

  assert_done_err_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(stat_done && stat_desc_err));

  assert_close_after_fill_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_done) |-> $past(state == S_CLOSE));

endmodule

bind rxd_ring_dma rxd_ring_dma_chk #(.LW(LW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .state         (state),
  .mem_rd        (mem_rd),
  .mem_wr        (mem_wr),
  .wdata_own     (mem_wdata[31]),
  .s_ready       (s_ready),
  .buf_cnt       (buf_cnt),
  .buf_size      (buf_size),
  .stat_done     (stat_done),
  .stat_desc_err (stat_desc_err)
);

// File: tb/sim_rxd_ring_dma.sv
`timescale 1ns/1ps
module sim_rxd_ring_dma;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic        flush_dis = 1'b0;
  logic        poll_req = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_last = 1'b0;
  logic        s_ready;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        stat_run, stat_susp, stat_done, stat_unavail, stat_desc_err;

  logic [31:0] mem [256];
  int total = 0;
  int bad = 0;
  int n_done = 0, n_unav = 0, n_err = 0, n_acc = 0, n_clash = 0, acc_words = 0;

  always #4 clk = ~clk;

  rxd_ring_dma #(.AW(16), .DW(32), .LW(16), .RING_BASE(0), .RING_LEN(4),
                 .POLL_CYCLES(64)) u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .flush_dis(flush_dis),
    .poll_req(poll_req), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .stat_run(stat_run),
    .stat_susp(stat_susp), .stat_done(stat_done), .stat_unavail(stat_unavail),
    .stat_desc_err(stat_desc_err)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (!rst) begin
      if (stat_done)     n_done++;
      if (stat_unavail)  n_unav++;
      if (stat_desc_err) n_err++;
      if (mem_rd || mem_wr) n_acc++;
      if (mem_rd && mem_wr) n_clash++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_desc(input int i, input logic own, input int size, input int addr);
    mem[i*4]   = {own, 31'b0};
    mem[i*4+1] = 32'(size);
    mem[i*4+2] = 32'(addr);
    mem[i*4+3] = '0;
  endtask

  task automatic poll();
    @(negedge clk) poll_req = 1'b1;
    @(negedge clk) poll_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input int n, input logic [31:0] seed, input string req);
    bit ok = 1'b1;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      int w = 0;
      s_valid = 1'b1;
      s_data  = seed + 32'(i);
      s_last  = (i == n - 1);
      while (!s_ready && w < 3000) begin
        @(negedge clk);
        w++;
      end
      if (w >= 3000) begin
        ok = 1'b0;
        break;
      end
      @(negedge clk);
      acc_words++;
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
    chk({req, " frame accepted"}, 32'(ok), 32'd1);
  endtask

  task automatic t_reset();
    idle(2);
    chk("R1 s_ready", 32'(s_ready), 0);
    chk("R1 mem access", 32'(mem_rd | mem_wr), 0);
    chk("R1 status", {27'b0, stat_run, stat_susp, stat_done, stat_unavail, stat_desc_err}, 0);
  endtask

  task automatic t_empty();
    int u0c = n_unav;
    run_en = 1'b1;
    idle(10);
    chk("R2 suspended", 32'(stat_susp), 1);
    chk("R2 unavailable pulse", 32'(n_unav - u0c), 1);
    chk("R2 running", 32'(stat_run), 1);
  endtask

  task automatic t_single();
    int d0 = n_done;
    set_desc(0, 1'b1, 8, 64);
    poll();
    send_frame(5, 32'h100, "R3");
    idle(10);
    for (int i = 0; i < 5; i++) chk("R3 buffer word", mem[64+i], 32'h100 + 32'(i));
    chk("R4 close word", mem[0], 32'h3000_0005);
    chk("R4 done pulse", 32'(n_done - d0), 1);
    chk("R9 poll resumed and re-suspended", 32'(stat_susp), 1);
  endtask

  task automatic t_chain();
    set_desc(1, 1'b1, 3, 80);
    set_desc(2, 1'b1, 4, 96);
    poll();
    send_frame(6, 32'h200, "R5");
    idle(10);
    chk("R5 first buffer close", mem[4], 32'h2000_0003);
    chk("R5 second buffer close", mem[8], 32'h1000_0006);
    chk("R5 data in first buffer", mem[82], 32'h202);
    chk("R5 data continues in second buffer", mem[96], 32'h203);
    chk("R5 data tail", mem[98], 32'h205);
  endtask

  task automatic t_wrap();
    set_desc(3, 1'b1, 2, 112);
    set_desc(0, 1'b1, 4, 64);
    poll();
    send_frame(2, 32'h300, "R6");
    send_frame(1, 32'h400, "R6");
    idle(10);
    chk("R6 last ring slot close", mem[12], 32'h3000_0002);
    chk("R6 wrapped slot data", mem[64], 32'h400);
    chk("R6 wrapped slot close", mem[0], 32'h3000_0001);
  endtask

  task automatic t_err();
    int e0 = n_err;
    int d0 = n_done;
    flush_dis = 1'b0;
    set_desc(1, 1'b1, 2, 80);
    poll();
    send_frame(5, 32'h500, "R7");
    idle(10);
    chk("R7 stored head", mem[81], 32'h501);
    chk("R7 error close word", mem[4], 32'h7000_0002);
    chk("R7 dropped words not written", mem[82], 32'h202);
    chk("R7 next buffer untouched", mem[96], 32'h203);
    chk("R7 error pulse", 32'(n_err - e0), 1);
    chk("R7 no done pulse", 32'(n_done - d0), 0);
    chk("R7 suspended", 32'(stat_susp), 1);
  endtask

  task automatic t_hold();
    int base_acc;
    flush_dis = 1'b1;
    set_desc(2, 1'b1, 2, 96);
    poll();
    base_acc = acc_words;
    fork
      send_frame(4, 32'h600, "R8");
      begin
        wait (acc_words == base_acc + 2);
        idle(10);
        chk("R8 stream stalled", 32'(s_ready), 0);
        chk("R8 stalled status", 32'(stat_susp), 1);
        chk("R8 open descriptor still engine-owned", 32'(mem[8][31]), 1);
        set_desc(3, 1'b1, 4, 112);
        poll();
      end
    join
    idle(10);
    chk("R8 open descriptor closed", mem[8], 32'h2000_0002);
    chk("R8 continuation close", mem[12], 32'h1000_0004);
    chk("R8 no word lost", mem[112], 32'h602);
    chk("R8 tail word", mem[113], 32'h603);
  endtask

  task automatic t_timer();
    set_desc(0, 1'b1, 4, 64);
    send_frame(1, 32'h700, "R10");
    idle(10);
    chk("R10 data after self re-poll", mem[64], 32'h700);
    chk("R10 close after self re-poll", mem[0], 32'h3000_0001);
  endtask

  task automatic t_stop();
    int a0;
    run_en = 1'b0;
    idle(80);
    chk("R11 stopped", 32'(stat_run), 0);
    a0 = n_acc;
    set_desc(1, 1'b1, 4, 80);
    idle(200);
    chk("R11 no accesses when stopped", 32'(n_acc - a0), 0);
    chk("R11 not suspended", 32'(stat_susp), 0);
    chk("R12 no read/write overlap", 32'(n_clash), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_empty();
    t_single();
    t_chain();
    t_wrap();
    t_err();
    t_hold();
    t_timer();
    t_stop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule